// File: doc/BRIEF.md
# Multi-Frequency Phase-Sensitive Demodulator

This block turns a stored set of signed voltage samples into in-phase and quadrature sums for up to three excitation frequencies at once. On a start request it walks the sample buffer from its first entry to its last, one read per clock. Each sample is multiplied by two reference values for every frequency lane: one at the lane's current table position, and one a quarter period further on. The reference values come from the shared 16-bit sine table that also drives the excitation, and the products are summed in wide accumulators.

Each lane owns a table position that starts at entry zero, where a reference period begins, and advances by a per-lane step. The step sets the frequency that lane demodulates. When more than three frequencies are needed, the pass is started again over the same buffer with new steps. While the pass reads the buffer the block reports busy. Once the last product has been summed, the results for all lanes appear together with a one-cycle valid pulse, a sticky done flag and a buffer-release pulse that returns the buffer to the acquisition side.

Top module: `psd_demod`

## Requirements
- R1: While reset is held and right after it, busy, done, result valid and buffer release are all low.
- R2: A start accepted when idle reads buffer addresses 0, 1, …, N_SAMPLES-1 on consecutive cycles. Busy is high from the cycle after the start edge until the sums are final. Result valid rises on the (N_SAMPLES+1)-th clock edge after the edge that sampled start. Buffer and table data are expected one cycle after their address.
- R3: Each result is the exact signed sum, over all samples, of an 18-bit signed sample times a 16-bit signed reference, held as a 44-bit two's-complement value. All N_SAMPLES=1000 products at the extreme values (-131072 times -32768, or 131071 times -32768) sum without overflow.
- R4: A lane's in-phase table address is 0 for the first sample and then advances by that lane's step modulo TABLE_LEN, once per sample. The step must be below TABLE_LEN.
- R5: A lane's quadrature table address is always (in-phase address + TABLE_LEN/4) modulo TABLE_LEN.
- R6: The three lanes use independent steps on the same samples. Lane l occupies bits [l*W +: W] of every packed lane port, with W the port's per-lane width.
- R7: Result valid is high for exactly one cycle per pass. Done rises with it, stays high while idle, and is low from the cycle after the next accepted start.
- R8: Buffer release is high only together with result valid, after busy has fallen. No buffer read is issued in that cycle.
- R9: A start that arrives while a pass is running is ignored. Step inputs are taken only at an accepted start, so changing them mid-pass does not alter the timing or the results of that pass.
- R10: A second pass over the unchanged buffer with different steps gives the sums for the new frequencies.
- R11: Result outputs change only in a cycle where result valid is high. They hold the previous pass's sums throughout the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one demodulation pass |
| step_i | input | LANES*ADDR_W | Per-lane table address increment |
| buf_rd_o | output | 1 | Sample buffer read enable |
| buf_addr_o | output | BUF_AW | Sample buffer address |
| buf_data_i | input | 18 | Signed sample, one cycle after its address |
| ref_i_addr_o | output | LANES*ADDR_W | In-phase table address per lane |
| ref_q_addr_o | output | LANES*ADDR_W | Quadrature table address per lane |
| ref_i_data_i | input | LANES*16 | In-phase reference values, one cycle after address |
| ref_q_data_i | input | LANES*16 | Quadrature reference values, one cycle after address |
| busy_o | output | 1 | Pass in progress, buffer in use |
| result_valid_o | output | 1 | One-cycle pulse: new results present |
| done_o | output | 1 | Sticky pass-complete flag |
| buf_release_o | output | 1 | Buffer handed back to acquisition |
| res_i_o | output | LANES*44 | In-phase sums per lane |
| res_q_o | output | LANES*44 | Quadrature sums per lane |

## Verification
The bench builds the block with its default parameters: 1000 samples, a 1000-entry table and three lanes. Every pass therefore runs the full summation window, and extreme-valued samples can drive the 44-bit sums to their true worst case. With a 1000-entry table, steps of 0, 999, 500 and 600 reach the modulo wrap of both the in-phase and the quarter-offset quadrature addresses. Back-to-back passes over one buffer load stand in for frequency sets larger than three.

// File: rtl/psd_pkg.sv
package psd_pkg;

  parameter int SMP_W = 18;
  parameter int REF_W = 16;
  parameter int ACC_W = 44;
  localparam int PROD_W = SMP_W + REF_W;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [REF_W-1:0] ref_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FIN
  } seq_st_e;

  // signed product widened to accumulator width
  function automatic acc_t mac_term(input smp_t s, input ref_t r);
    logic signed [PROD_W-1:0] p;
    p = s * r;
    return acc_t'(p);
  endfunction

  // modular table step, both operands below len
  function automatic int wrap_add(input int a, input int b, input int len);
    int s;
    s = a + b;
    if (s >= len) s = s - len;
    return s;
  endfunction

endpackage

// File: rtl/psd_seq.sv
module psd_seq
  import psd_pkg::*;
#(
  parameter int N_SAMPLES = 1000,
  parameter int BUF_AW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              rd_o,
  output logic [BUF_AW-1:0] rd_idx_o,
  output logic              acc_en_o,
  output logic              final_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              done_o
);

  localparam logic [BUF_AW-1:0] LAST_IDX = BUF_AW'(N_SAMPLES - 1);

  seq_st_e           st;
  logic [BUF_AW-1:0] idx;
  logic              acc_en_q;
  logic              done_q;

  assign accept_o = start_i && ((st == ST_IDLE) || (st == ST_FIN));
  assign rd_o     = (st == ST_RUN);
  assign rd_idx_o = idx;
  assign acc_en_o = acc_en_q;
  assign final_o  = acc_en_q && (st == ST_DRAIN);
  assign busy_o   = (st == ST_RUN) || (st == ST_DRAIN);
  assign valid_o  = (st == ST_FIN);
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      acc_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      acc_en_q <= (st == ST_RUN);
      case (st)
        ST_IDLE, ST_FIN: begin
          if (accept_o) begin
            st     <= ST_RUN;
            idx    <= '0;
            done_q <= 1'b0;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (idx == LAST_IDX) st <= ST_DRAIN;
          else                 idx <= idx + 1'b1;
        end
        ST_DRAIN: begin
          st     <= ST_FIN;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psd_lane_addr.sv
module psd_lane_addr
  import psd_pkg::*;
#(
  parameter int TABLE_LEN = 1000,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_i_o,
  output logic [ADDR_W-1:0] addr_q_o
);

  localparam int QUARTER = TABLE_LEN / 4;

  logic [ADDR_W-1:0] phase;
  logic [ADDR_W-1:0] step_q;

  assign addr_i_o = phase;
  assign addr_q_o = ADDR_W'(wrap_add(int'(phase), QUARTER, TABLE_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      step_q <= '0;
    end else if (load_i) begin
      phase  <= '0;
      step_q <= step_i;
    end else if (adv_i) begin
      phase <= ADDR_W'(wrap_add(int'(phase), int'(step_q), TABLE_LEN));
    end
  end

endmodule

// File: rtl/psd_mac_lane.sv
module psd_mac_lane
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic acc_en_i,
  input  logic final_i,
  input  smp_t smp_i,
  input  ref_t ref_i_i,
  input  ref_t ref_q_i,
  output acc_t res_i_o,
  output acc_t res_q_o
);

  acc_t acc_i, acc_q;
  acc_t nxt_i, nxt_q;

  assign nxt_i = acc_i + mac_term(smp_i, ref_i_i);
  assign nxt_q = acc_q + mac_term(smp_i, ref_q_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_i   <= '0;
      acc_q   <= '0;
      res_i_o <= '0;
      res_q_o <= '0;
    end else begin
      if (clr_i) begin
        acc_i <= '0;
        acc_q <= '0;
      end else if (acc_en_i) begin
        acc_i <= nxt_i;
        acc_q <= nxt_q;
      end
      if (acc_en_i && final_i) begin
        res_i_o <= nxt_i;
        res_q_o <= nxt_q;
      end
    end
  end

endmodule

// File: rtl/psd_demod.sv
module psd_demod
  import psd_pkg::*;
#(
  parameter int N_SAMPLES = 1000,
  parameter int TABLE_LEN = 1000,
  parameter int LANES     = 3,
  localparam int ADDR_W   = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1,
  localparam int BUF_AW   = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LANES*ADDR_W-1:0] step_i,
  output logic                    buf_rd_o,
  output logic [BUF_AW-1:0]       buf_addr_o,
  input  logic [SMP_W-1:0]        buf_data_i,
  output logic [LANES*ADDR_W-1:0] ref_i_addr_o,
  output logic [LANES*ADDR_W-1:0] ref_q_addr_o,
  input  logic [LANES*REF_W-1:0]  ref_i_data_i,
  input  logic [LANES*REF_W-1:0]  ref_q_data_i,
  output logic                    busy_o,
  output logic                    result_valid_o,
  output logic                    done_o,
  output logic                    buf_release_o,
  output logic [LANES*ACC_W-1:0]  res_i_o,
  output logic [LANES*ACC_W-1:0]  res_q_o
);

  // named internal events
  logic accept;
  logic rd;
  logic acc_en;
  logic final_acc;

  psd_seq #(
    .N_SAMPLES(N_SAMPLES),
    .BUF_AW   (BUF_AW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .accept_o(accept),
    .rd_o    (rd),
    .rd_idx_o(buf_addr_o),
    .acc_en_o(acc_en),
    .final_o (final_acc),
    .busy_o  (busy_o),
    .valid_o (result_valid_o),
    .done_o  (done_o)
  );

  assign buf_rd_o      = rd;
  assign buf_release_o = result_valid_o;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    psd_lane_addr #(
      .TABLE_LEN(TABLE_LEN),
      .ADDR_W   (ADDR_W)
    ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .adv_i   (rd),
      .step_i  (step_i[l*ADDR_W +: ADDR_W]),
      .addr_i_o(ref_i_addr_o[l*ADDR_W +: ADDR_W]),
      .addr_q_o(ref_q_addr_o[l*ADDR_W +: ADDR_W])
    );

    psd_mac_lane u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept),
      .acc_en_i(acc_en),
      .final_i (final_acc),
      .smp_i   (buf_data_i),
      .ref_i_i (ref_i_data_i[l*REF_W +: REF_W]),
      .ref_q_i (ref_q_data_i[l*REF_W +: REF_W]),
      .res_i_o (res_i_o[l*ACC_W +: ACC_W]),
      .res_q_o (res_q_o[l*ACC_W +: ACC_W])
    );
  end

endmodule

// File: rtl/psd_demod_chk.sv
module psd_demod_chk
  import psd_pkg::*;
#(
  parameter int LANES     = 3,
  parameter int TABLE_LEN = 1000,
  parameter int ADDR_W    = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    buf_rd_o,
  input logic                    busy_o,
  input logic                    result_valid_o,
  input logic                    done_o,
  input logic                    buf_release_o,
  input logic                    acc_en,
  input logic                    final_acc,
  input logic [LANES*ADDR_W-1:0] ref_i_addr_o,
  input logic [LANES*ADDR_W-1:0] ref_q_addr_o,
  input logic [LANES*ACC_W-1:0]  res_i_o,
  input logic [LANES*ACC_W-1:0]  res_q_o
);

  p_read_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |-> busy_o);

  p_read_feeds_mac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |=> acc_en);

  for (genvar l = 0; l < LANES; l++) begin : g_rng
    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i_addr_o[l*ADDR_W +: ADDR_W] < TABLE_LEN) &&
      (ref_q_addr_o[l*ADDR_W +: ADDR_W] < TABLE_LEN));
  end

  p_final_then_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    final_acc |=> result_valid_o);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  p_done_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> done_o);

  p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release_o |-> (result_valid_o && !busy_o && !buf_rd_o));

  p_release_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release_o |-> $past(busy_o));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_o && start_i) |=> busy_o);

  p_results_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(res_i_o) || !$stable(res_q_o)) |-> result_valid_o);

endmodule

bind psd_demod psd_demod_chk #(
  .LANES    (LANES),
  .TABLE_LEN(TABLE_LEN),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .buf_rd_o      (buf_rd_o),
  .busy_o        (busy_o),
  .result_valid_o(result_valid_o),
  .done_o        (done_o),
  .buf_release_o (buf_release_o),
  .acc_en        (acc_en),
  .final_acc     (final_acc),
  .ref_i_addr_o  (ref_i_addr_o),
  .ref_q_addr_o  (ref_q_addr_o),
  .res_i_o       (res_i_o),
  .res_q_o       (res_q_o)
);

// File: tb/psd_demod_test.sv
module psd_demod_test;

  localparam int N  = 1000;
  localparam int TL = 1000;
  localparam int NL = 3;
  localparam int AW = $clog2(TL);
  localparam int BW = $clog2(N);
  localparam int QW = 44;
  localparam int NV = 6;

  // smp_mode, tbl_mode, step0, step1, step2
  localparam int VEC [NV][5] = '{
    '{0, 0, 1,   7,   250},
    '{1, 0, 0,   999, 500},
    '{2, 0, 3,   11,  13},
    '{2, 0, 997, 2,   600},
    '{3, 1, 1,   2,   3},
    '{4, 1, 5,   0,   999}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NL*AW-1:0] step_i = '0;
  logic buf_rd_o;
  logic [BW-1:0] buf_addr_o;
  logic [17:0] buf_data_i;
  logic [NL*AW-1:0] ref_i_addr_o, ref_q_addr_o;
  logic [NL*16-1:0] ref_i_data_i, ref_q_data_i;
  logic busy_o, result_valid_o, done_o, buf_release_o;
  logic [NL*QW-1:0] res_i_o, res_q_o;

  always #4 clk = ~clk;

  psd_demod uut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic signed [17:0] smp_mem [N];
  int tbl_mode = 0;
  logic [NL*AW-1:0] ri_reg, rq_reg;
  logic [17:0] buf_q;
  longint exp_i [NL], exp_q [NL], prev_i [NL], prev_q [NL];

  function automatic logic signed [17:0] gen_smp(input int mode, input int k);
    int v;
    case (mode)
      0: v = k * 131 - 65000;
      1: v = (k % 2 == 1) ? -(k * 100) : (k * 100 + 5);
      2: v = ((k * 40503 + 12345) % 262144) - 131072;
      3: v = -131072;
      default: v = 131071;
    endcase
    return 18'(v);
  endfunction

  function automatic logic signed [15:0] tbl(input int mode, input int a);
    if (mode == 1) return -16'sd32768;
    return 16'(a * 131 + 7);
  endfunction

  // memory models with one cycle of read latency
  always @(posedge clk) begin
    if (buf_rd_o) buf_q <= smp_mem[buf_addr_o];
    ri_reg <= ref_i_addr_o;
    rq_reg <= ref_q_addr_o;
  end
  assign buf_data_i = buf_q;
  always_comb begin
    for (int l = 0; l < NL; l++) begin
      ref_i_data_i[l*16 +: 16] = tbl(tbl_mode, int'(ri_reg[l*AW +: AW]));
      ref_q_data_i[l*16 +: 16] = tbl(tbl_mode, int'(rq_reg[l*AW +: AW]));
    end
  end

  task automatic check(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint lane_res(input logic [NL*QW-1:0] v, input int l);
    logic signed [QW-1:0] x;
    x = v[l*QW +: QW];
    return longint'(x);
  endfunction

  task automatic load_buf(input int mode);
    for (int k = 0; k < N; k++) smp_mem[k] = gen_smp(mode, k);
  endtask

  task automatic calc_exp(input int s0, input int s1, input int s2);
    int st [NL];
    st = '{s0, s1, s2};
    for (int l = 0; l < NL; l++) begin
      int p;
      p = 0;
      exp_i[l] = 0;
      exp_q[l] = 0;
      for (int k = 0; k < N; k++) begin
        exp_i[l] += longint'(smp_mem[k]) * longint'(tbl(tbl_mode, p));
        exp_q[l] += longint'(smp_mem[k]) * longint'(tbl(tbl_mode, (p + TL / 4) % TL));
        p = (p + st[l]) % TL;
      end
    end
  endtask

  task automatic do_pass(input int s0, input int s1, input int s2,
                         input bit meddle, input bit hold_chk);
    int ph [NL];
    int st [NL];
    int lat, rdn, bad_rd, bad_ad;
    ph = '{0, 0, 0};
    st = '{s0, s1, s2};
    rdn = 0; bad_rd = 0; bad_ad = 0;
    calc_exp(s0, s1, s2);
    step_i = {AW'(s2), AW'(s1), AW'(s0)};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    check("R7 done cleared by start", longint'(done_o), 0);
    check("R2 busy after start", longint'(busy_o), 1);
    while (!result_valid_o && lat < N + 20) begin
      if (buf_rd_o) begin
        if (int'(buf_addr_o) != rdn) bad_rd++;
        for (int l = 0; l < NL; l++) begin
          if (int'(ref_i_addr_o[l*AW +: AW]) != ph[l]) bad_ad++;
          if (int'(ref_q_addr_o[l*AW +: AW]) != (ph[l] + TL / 4) % TL) bad_ad++;
          ph[l] = (ph[l] + st[l]) % TL;
        end
        rdn++;
      end
      if (hold_chk && lat == 100) begin
        for (int l = 0; l < NL; l++) begin
          check("R11 in-phase held mid-pass", lane_res(res_i_o, l), prev_i[l]);
          check("R11 quadrature held mid-pass", lane_res(res_q_o, l), prev_q[l]);
        end
      end
      if (meddle && lat == 10) begin
        start_i = 1'b1;
        step_i = {AW'(9), AW'(8), AW'(4)};
      end
      if (meddle && lat == 11) start_i = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(meddle ? "R9 latency with ignored start" : "R2 latency", lat, N + 2);
    check("R2 read count", rdn, N);
    check("R2 read address order", bad_rd, 0);
    check("R4 R5 table address mismatches", bad_ad, 0);
    for (int l = 0; l < NL; l++) begin
      check(meddle ? "R9 in-phase sum" : "R3 R6 in-phase sum", lane_res(res_i_o, l), exp_i[l]);
      check(meddle ? "R9 quadrature sum" : "R3 R6 quadrature sum", lane_res(res_q_o, l), exp_q[l]);
    end
    check("R7 done with valid", longint'(done_o), 1);
    check("R8 release with valid", longint'(buf_release_o), 1);
    check("R8 busy low at release", longint'(busy_o), 0);
    @(negedge clk);
    check("R7 valid single cycle", longint'(result_valid_o), 0);
    check("R8 release single cycle", longint'(buf_release_o), 0);
    check("R7 done sticky", longint'(done_o), 1);
    prev_i = exp_i;
    prev_q = exp_q;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", longint'(busy_o), 0);
    check("R1 done in reset", longint'(done_o), 0);
    check("R1 valid in reset", longint'(result_valid_o), 0);
    check("R1 release in reset", longint'(buf_release_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", longint'({busy_o, done_o, result_valid_o, buf_release_o}), 0);

    // vector table; consecutive entries sharing a buffer mode are reruns (R10)
    for (int v = 0; v < NV; v++) begin
      if (v == 0 || VEC[v][0] != VEC[v-1][0]) load_buf(VEC[v][0]);
      tbl_mode = VEC[v][1];
      do_pass(VEC[v][2], VEC[v][3], VEC[v][4], 1'b0, v > 0);
      repeat (2) @(negedge clk);
    end

    // R9: start and step change during a running pass are ignored
    load_buf(0);
    tbl_mode = 0;
    do_pass(17, 250, 333, 1'b1, 1'b1);

    // R11 / R7: idle cycles keep done and results
    repeat (20) @(negedge clk);
    check("R7 done still set when idle", longint'(done_o), 1);
    check("R11 results stable when idle", lane_res(res_q_o, 2), prev_q[2]);
    check("R10 buffer untouched while idle", longint'(buf_rd_o), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule